// File: doc/BRIEF.md
# Tweak Sequence Generator for Block-Cipher XTS Mode

This block produces the run of per-block tweak values that XTS-style encryption and decryption consume. A host first loads an encrypted starting tweak. Each accepted step strobe then presents the current tweak on a registered, valid-qualified output and advances the internal state. The step multiplies the state by the field generator alpha in GF(2^128), using the reduction polynomial x^128 + x^7 + x^2 + x + 1. Encryption and decryption use the same sequence, so one generator serves both directions.

A pair mode serves datapaths that consume two blocks per cycle. In this mode one step presents the current tweak and its product with alpha together, and the state advances by alpha squared. The 128-bit value is little-endian: bit 0 of byte 0 is the least significant bit. Internally the value is kept as two 64-bit halves, and the carries between the halves and out of the top are handled explicitly.

Top module: `twk_seq_gen`

## Requirements
- R1: After synchronous reset, `twk_vld` and `twk_pair` are 0, and `twk0` and `twk1` are all zeros.
- R2: A step accepted after a load drives `twk_vld` high for exactly the following cycle. In that cycle `twk0` holds the state as it was when the step was sampled.
- R3: With single steps, the n-th output after a load of T equals T·alpha^n for n = 0..15 and beyond. Multiplying by alpha is a one-bit left shift of the whole 128-bit value.
- R4: When alpha is applied, the bit leaving bit 63 enters bit 64, the least significant bit of the upper half.
- R5: When alpha is applied and bit 127 was 1, the value 0x87 is XORed into byte 0 (bits 7:0) after the shift.
- R6: A step with `pair` high presents T·alpha^k on `twk0` and T·alpha^(k+1) on `twk1`, with `twk_pair` high, and advances the state by alpha squared. For alpha squared, bits 127 and 126 fold back as 0x0E into byte 0 and 0x01 into byte 1 (bit 127) and as 0x87 into byte 0 (bit 126). Bits 63 and 62 land in bits 65 and 64.
- R7: When `ld` and `step` are high in the same cycle, the load wins. No output is produced in the next cycle, and the next step presents the newly loaded tweak.
- R8: A step before the first load after reset is ignored: `twk_vld` stays 0.
- R9: Without a step, `twk_vld` and `twk_pair` return to 0 and the state is kept, so that a later step resumes the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Load strobe for a new starting tweak |
| ld_tweak | input | 128 | Starting tweak, little-endian |
| step | input | 1 | Advance strobe |
| pair | input | 1 | With `step`: emit two tweaks and advance by alpha squared |
| twk0 | output | 128 | Current tweak |
| twk1 | output | 128 | Current tweak times alpha (pair mode), zero otherwise |
| twk_vld | output | 1 | `twk0` holds a fresh tweak this cycle |
| twk_pair | output | 1 | `twk1` also holds a fresh tweak this cycle |

## Verification
The hardest condition to reach from the ports is a step in which bits 127 and 63 are both set, so that the top-bit reduction and the carry between halves happen together. For alpha squared, the same applies to bits 127, 126, 63 and 62. Several starting tweaks are chosen so that these bits are set at load time, and others so that the shifting sequence walks into them after a few steps. Every output is compared against a bit-serial field multiply of the loaded tweak by a power of two. A load colliding with a step, a step before any load, and idle gaps inside a sequence are driven as directed cases.

// File: rtl/twk_pkg.sv
package twk_pkg;

    localparam int BLK_W  = 128;
    localparam int HALF_W = BLK_W / 2;
    localparam logic [7:0] FOLD1 = 8'h87;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } twk_t;

    function automatic twk_t mul_a(input twk_t x);
        twk_t r;
        r.lo = {x.lo[HALF_W-2:0], 1'b0};
        r.hi = {x.hi[HALF_W-2:0], x.lo[HALF_W-1]};
        if (x.hi[HALF_W-1]) r.lo[7:0] = r.lo[7:0] ^ FOLD1;
        return r;
    endfunction

    function automatic twk_t mul_a2(input twk_t x);
        twk_t r;
        logic [15:0] fold;
        r.lo = {x.lo[HALF_W-3:0], 2'b00};
        r.hi = {x.hi[HALF_W-3:0], x.lo[HALF_W-1:HALF_W-2]};
        fold = 16'h0000;
        if (x.hi[HALF_W-2]) fold = fold ^ {8'h00, FOLD1};
        if (x.hi[HALF_W-1]) fold = fold ^ 16'h010E;
        r.lo[15:0] = r.lo[15:0] ^ fold;
        return r;
    endfunction

endpackage

// File: rtl/twk_mul.sv
module twk_mul
    import twk_pkg::*;
#(
    parameter int SHIFT = 1
) (
    input  twk_t x,
    output twk_t y
);
    generate
        if (SHIFT == 2) begin : g_sq
            assign y = mul_a2(x);
        end else begin : g_one
            assign y = mul_a(x);
        end
    endgenerate
endmodule

// File: rtl/twk_state.sv
module twk_state
    import twk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  twk_t ld_val,
    input  logic adv,
    input  logic dbl,
    input  twk_t nxt1,
    input  twk_t nxt2,
    output twk_t cur,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            armed <= 1'b0;
        end else if (ld) begin
            cur   <= ld_val;
            armed <= 1'b1;
        end else if (adv && armed) begin
            cur <= dbl ? nxt2 : nxt1;
        end
    end
endmodule

// File: rtl/twk_out_reg.sv
module twk_out_reg
    import twk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic dbl,
    input  twk_t cur,
    input  twk_t nxt1,
    output twk_t o0,
    output twk_t o1,
    output logic vld,
    output logic pv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            o0  <= '0;
            o1  <= '0;
            vld <= 1'b0;
            pv  <= 1'b0;
        end else if (fire) begin
            o0  <= cur;
            o1  <= dbl ? nxt1 : '0;
            vld <= 1'b1;
            pv  <= dbl;
        end else begin
            vld <= 1'b0;
            pv  <= 1'b0;
        end
    end
endmodule

// File: rtl/twk_seq_gen.sv
module twk_seq_gen
    import twk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [BLK_W-1:0] ld_tweak,
    input  logic             step,
    input  logic             pair,
    output logic [BLK_W-1:0] twk0,
    output logic [BLK_W-1:0] twk1,
    output logic             twk_vld,
    output logic             twk_pair
);
    twk_t cur, nxt1, nxt2, o0, o1;
    logic armed, fire;

    assign fire = step && !ld && armed;

    twk_mul #(.SHIFT(1)) u_m1 (.x(cur), .y(nxt1));
    twk_mul #(.SHIFT(2)) u_m2 (.x(cur), .y(nxt2));

    twk_state u_st (
        .clk(clk), .rst(rst), .ld(ld), .ld_val(twk_t'(ld_tweak)),
        .adv(step), .dbl(pair), .nxt1(nxt1), .nxt2(nxt2),
        .cur(cur), .armed(armed)
    );

    twk_out_reg u_out (
        .clk(clk), .rst(rst), .fire(fire), .dbl(pair),
        .cur(cur), .nxt1(nxt1),
        .o0(o0), .o1(o1), .vld(twk_vld), .pv(twk_pair)
    );

    assign twk0 = o0;
    assign twk1 = o1;
endmodule

// File: rtl/twk_seq_gen_chk.sv
module twk_seq_gen_chk
    import twk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ld,
    input logic             step,
    input logic [BLK_W-1:0] twk0,
    input logic [BLK_W-1:0] twk1,
    input logic             twk_vld,
    input logic             twk_pair
);
    logic seen_ld;
    always_ff @(posedge clk) begin
        if (rst) seen_ld <= 1'b0;
        else if (ld) seen_ld <= 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !twk_vld && !twk_pair) else $error("R1"); // R1
    AST_STEP_VALID: assert property (@(posedge clk) disable iff (rst) (step && !ld && seen_ld) |=> twk_vld) else $error("R2"); // R2
    AST_CHAIN_ALPHA: assert property (@(posedge clk) disable iff (rst)
        (twk_vld && $past(twk_vld) && !$past(twk_pair)) |-> (twk_t'(twk0) == mul_a(twk_t'($past(twk0))))) else $error("R3"); // R3
    AST_PAIR_REL: assert property (@(posedge clk) disable iff (rst)
        twk_pair |-> (twk_vld && twk_t'(twk1) == mul_a(twk_t'(twk0)))) else $error("R6"); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst) ld |=> !twk_vld) else $error("R7"); // R7
    AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst) (!seen_ld && !ld) |=> !twk_vld) else $error("R8"); // R8
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst) !step |=> !twk_vld && !twk_pair) else $error("R9"); // R9
endmodule

bind twk_seq_gen twk_seq_gen_chk u_chk (
    .clk(clk), .rst(rst), .ld(ld), .step(step),
    .twk0(twk0), .twk1(twk1), .twk_vld(twk_vld), .twk_pair(twk_pair)
);

// File: tb/tb_twk_seq_gen.sv
module tb_twk_seq_gen;
    logic clk = 1'b0;
    logic rst, ld, step, pair;
    logic [127:0] ld_tweak, twk0, twk1;
    logic twk_vld, twk_pair;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    twk_seq_gen dut (
        .clk(clk), .rst(rst), .ld(ld), .ld_tweak(ld_tweak), .step(step), .pair(pair),
        .twk0(twk0), .twk1(twk1), .twk_vld(twk_vld), .twk_pair(twk_pair)
    );

    localparam int NV = 7;
    localparam logic [127:0] SEEDS [NV] = '{
        128'h8000_0000_0000_0000_8000_0000_0000_0000,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h0000_0000_0000_0000_0000_0000_0000_0001,
        128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321,
        128'hC000_0000_0000_0000_C000_0000_0000_0000,
        128'h0001_0000_0000_0000_0001_0000_0000_0000,
        128'hC3A5_5A3C_F00F_0FF0_E1D2_C3B4_A596_8778
    };
    localparam logic [NV-1:0] PAIRV = 7'b1010100;

    function automatic logic [127:0] gf_mul(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        logic [127:0] x = a;
        for (int i = 0; i < 128; i++) begin
            logic msb;
            if (b[i]) r = r ^ x;
            msb = x[127];
            x = x << 1;
            if (msb) x = x ^ 128'h87;
        end
        return r;
    endfunction

    function automatic logic [127:0] apow(input int n);
        return 128'd1 << n;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [127:0] v);
        @(negedge clk); ld = 1'b1; ld_tweak = v;
        @(negedge clk); ld = 1'b0;
    endtask

    task automatic do_step(input logic p);
        @(negedge clk); step = 1'b1; pair = p;
        @(negedge clk); step = 1'b0; pair = 1'b0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ld = 1'b0; step = 1'b0; pair = 1'b0; ld_tweak = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 vld", 128'(twk_vld), 128'd0);
        chk("R1 pair", 128'(twk_pair), 128'd0);
        chk("R1 twk0", twk0, '0);
        chk("R1 twk1", twk1, '0);
        rst = 1'b0;
        // R8 step before any load
        do_step(1'b0);
        chk("R8 vld", 128'(twk_vld), 128'd0);
        do_step(1'b1);
        chk("R8 pair vld", 128'(twk_vld), 128'd0);

        // table walk: R3, R4, R5 single; R6 pair
        for (int v = 0; v < NV; v++) begin
            do_load(SEEDS[v]);
            if (!PAIRV[v]) begin
                for (int n = 0; n < 20; n++) begin
                    do_step(1'b0);
                    chk("R2 vld", 128'(twk_vld), 128'd1);
                    chk("R3 R4 R5 twk0", twk0, gf_mul(SEEDS[v], apow(n)));
                end
            end else begin
                for (int k = 0; k < 10; k++) begin
                    do_step(1'b1);
                    chk("R6 pair", 128'(twk_pair), 128'd1);
                    chk("R6 twk0", twk0, gf_mul(SEEDS[v], apow(2 * k)));
                    chk("R6 twk1", twk1, gf_mul(SEEDS[v], apow(2 * k + 1)));
                end
            end
        end

        // R4/R5 directed: bits 127 and 63 both set, one alpha step
        do_load(128'h8000_0000_0000_0000_8000_0000_0000_0000);
        do_step(1'b0); do_step(1'b0);
        chk("R4 R5 combined", twk0, 128'h0000_0000_0000_0001_0000_0000_0000_0087);

        // R6 directed: fold of bits 127,126 and crossing of 63,62
        do_load(128'hC000_0000_0000_0000_C000_0000_0000_0000);
        do_step(1'b1); do_step(1'b0);
        chk("R6 fold", twk0, 128'h0000_0000_0000_0003_0000_0000_0000_0189);

        // R2 single-cycle pulse
        @(negedge clk);
        chk("R2 pulse end", 128'(twk_vld), 128'd0);

        // R7 load wins over step
        do_load(128'h5);
        do_step(1'b0);
        @(negedge clk); ld = 1'b1; step = 1'b1; ld_tweak = 128'h77;
        @(negedge clk); ld = 1'b0; step = 1'b0;
        chk("R7 no output", 128'(twk_vld), 128'd0);
        do_step(1'b0);
        chk("R7 new tweak", twk0, 128'h77);

        // R9 idle gap keeps state
        repeat (4) @(negedge clk);
        chk("R9 vld idle", 128'(twk_vld), 128'd0);
        do_step(1'b0);
        chk("R9 resume", twk0, gf_mul(128'h77, apow(1)));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule